// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block watches the shared clock and data lines of a two-wire bus. It finds START and STOP conditions and keeps a pair of sticky, mutually exclusive status bits: one that says a START was the last condition seen, and one that says it was a STOP. A bus-free output is formed from these bits, so that a master run by firmware can tell when it is allowed to drive the bus, including the period straight after reset when no condition has been seen yet.

An interrupt flag is raised by a START, by a STOP, and by a single-cycle byte-complete pulse from external shift logic. The flag holds until firmware pulses a clear input. The interrupt output is the flag gated by an interrupt-enable input. A module-enable input clears both status bits and blocks every source of the flag while it is low. Address matching, byte shifting and clock generation are handled elsewhere.

Both bus lines go through a synchroniser (two flops by default) and then a one-flop history stage before the edge comparison. A line change that is first captured at clock edge n therefore shows up in the status bits at edge n+2.

Top module: `i2c_cond_monitor`

## Requirements
- R1: After reset, `start_seen` and `stop_seen` are 0, `bus_free` is 1, and `irq_flag` and `irq` are 0.
- R2: A START is SDA going from 1 to 0 while SCL is 1 in both the old and new synchronised samples. When enabled, it sets `start_seen` and clears `stop_seen` at edge n+2, where edge n first captures the falling SDA.
- R3: A STOP is SDA going from 0 to 1 while SCL is 1 in both samples. When enabled, it sets `stop_seen` and clears `start_seen` with the same n+2 timing.
- R4: An SDA change while SCL is 0, or while SCL changes in the same sample, is not a condition and leaves both status bits and the flag unchanged.
- R5: `bus_free` is 1 when `stop_seen` is 1, or when both status bits are 0. Otherwise it is 0.
- R6: `start_seen` and `stop_seen` are never 1 at the same time.
- R7: While `enable` is 0, both status bits are cleared at the next edge, and START, STOP and `byte_done` do not set the flag.
- R8: When enabled, a START, a STOP or a `byte_done` pulse sets `irq_flag` at the same edge that updates the status bits. For `byte_done`, that is the edge that samples the pulse.
- R9: `irq_flag` stays set until a `flag_clr` pulse clears it at the next edge. If a set event falls in the same cycle as `flag_clr`, the flag ends up set.
- R10: `irq` is `irq_flag` AND `irq_en` with no register between them. If `irq_en` is raised while the bus is busy and the flag is clear, `irq` first rises on the following STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable |
| scl_in | input | 1 | Bus clock line level (asynchronous) |
| sda_in | input | 1 | Bus data line level (asynchronous) |
| byte_done | input | 1 | Single-cycle pulse when a byte has been shifted |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Single-cycle pulse that clears the interrupt flag |
| start_seen | output | 1 | Sticky: last condition seen was a START |
| stop_seen | output | 1 | Sticky: last condition seen was a STOP |
| bus_free | output | 1 | Bus may be taken by a master |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq | output | 1 | Interrupt request (flag gated by enable) |

## Verification
A line change is first sampled at edge n and must appear in the status bits and the flag at edge n+2. `byte_done` and `flag_clr` act at the very edge that samples them, and `irq` and `bus_free` follow their inputs within the same cycle. The bench drives inputs just after the falling edge and keeps a queue of past line samples. Its reference state is stepped at each rising edge using the queue entries that are two and three edges old, and the outputs are compared at every falling edge, so each result is checked in exactly the cycle it is due. Directed checks at chosen points confirm the exclusion, disable, collision and ignored-transition cases with literal expected values.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef struct packed {
        logic s;      // last condition was START
        logic p;      // last condition was STOP
        logic flag;   // sticky interrupt flag
    } i2cm_stat_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } i2cm_lines_t;

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
    parameter int STAGES  = 2,
    parameter int WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb stage_d[g] = async_i;
        end else begin : g_chain
            always_comb stage_d[g] = stage_q[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_d[g];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/i2cm_cond_det.sv
module i2cm_cond_det
    import i2cm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  i2cm_lines_t now_i,
    output logic        start_o,
    output logic        stop_o
);

    i2cm_lines_t hist_d, hist_q;
    logic        scl_steady_hi;

    always_comb begin
        hist_d        = now_i;
        scl_steady_hi = now_i.scl & hist_q.scl;
        start_o       = scl_steady_hi &  hist_q.sda & ~now_i.sda;
        stop_o        = scl_steady_hi & ~hist_q.sda &  now_i.sda;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '{scl: 1'b1, sda: 1'b1};
        else        hist_q <= hist_d;
    end

    AST_ONE_COND_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !stop_o); // R4

endmodule

// File: rtl/i2cm_status.sv
module i2cm_status
    import i2cm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic start_i,
    input  logic stop_i,
    input  logic byte_done_i,
    input  logic clr_i,
    output logic s_o,
    output logic p_o,
    output logic flag_o
);

    i2cm_stat_t st_d, st_q;
    logic       set_evt;

    always_comb begin
        st_d    = st_q;
        set_evt = en_i & (start_i | stop_i | byte_done_i);

        if (!en_i) begin
            st_d.s = 1'b0;
            st_d.p = 1'b0;
        end else if (start_i) begin
            st_d.s = 1'b1;
            st_d.p = 1'b0;
        end else if (stop_i) begin
            st_d.s = 1'b0;
            st_d.p = 1'b1;
        end

        if (set_evt)    st_d.flag = 1'b1;
        else if (clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s_o    = st_q.s;
    assign p_o    = st_q.p;
    assign flag_o = st_q.flag;

    AST_SP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.s && st_q.p)); // R6
    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && start_i) |=> (s_o && !p_o && flag_o)); // R2
    AST_STOP_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && stop_i) |=> (p_o && !s_o && flag_o)); // R3
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!s_o && !p_o)); // R7
    AST_BYTE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && byte_done_i) |=> flag_o); // R8
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o); // R9

endmodule

// File: rtl/i2c_cond_monitor.sv
module i2c_cond_monitor
    import i2cm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_in,
    input  logic sda_in,
    input  logic byte_done,
    input  logic irq_en,
    input  logic flag_clr,
    output logic start_seen,
    output logic stop_seen,
    output logic bus_free,
    output logic irq_flag,
    output logic irq
);

    localparam int LINES = $bits(i2cm_lines_t);

    i2cm_lines_t raw_lines, sync_lines;
    logic        start_det, stop_det;

    assign raw_lines = '{scl: scl_in, sda: sda_in};

    i2cm_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (LINES),
        .RST_VAL({LINES{1'b1}})
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_lines),
        .sync_o (sync_lines)
    );

    i2cm_cond_det u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .now_i  (sync_lines),
        .start_o(start_det),
        .stop_o (stop_det)
    );

    i2cm_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (enable),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .byte_done_i(byte_done),
        .clr_i      (flag_clr),
        .s_o        (start_seen),
        .p_o        (stop_seen),
        .flag_o     (irq_flag)
    );

    assign bus_free = stop_seen | (~start_seen & ~stop_seen);
    assign irq      = irq_flag & irq_en;

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_flag && irq_en)); // R10
    AST_BUSY_NOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_seen && !stop_seen) |-> !bus_free); // R5

endmodule

// File: tb/i2c_cond_monitor_tb_top.sv
`timescale 1ns/1ps
module i2c_cond_monitor_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, scl_in = 1'b1, sda_in = 1'b1;
    logic byte_done = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
    logic start_seen, stop_seen, bus_free, irq_flag, irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    i2c_cond_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .scl_in(scl_in), .sda_in(sda_in), .byte_done(byte_done),
        .irq_en(irq_en), .flag_clr(flag_clr),
        .start_seen(start_seen), .stop_seen(stop_seen),
        .bus_free(bus_free), .irq_flag(irq_flag), .irq(irq)
    );

    // ---------------- reference model ----------------
    bit hscl[$];
    bit hsda[$];
    bit m_s = 0, m_p = 0, m_flag = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hscl = '{1, 1, 1};
            hsda = '{1, 1, 1};
            m_s = 0; m_p = 0; m_flag = 0;
        end else begin
            // [1] is the sample from two edges ago, [2] from three
            bit st, sp, ev;
            st = hscl[1] && hscl[2] && hsda[2] && !hsda[1];
            sp = hscl[1] && hscl[2] && !hsda[2] && hsda[1];
            ev = enable && (st || sp || byte_done);
            if (!enable) begin m_s = 0; m_p = 0; end
            else if (st) begin m_s = 1; m_p = 0; end
            else if (sp) begin m_s = 0; m_p = 1; end
            if (ev) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            hscl.push_front(scl_in); void'(hscl.pop_back());
            hsda.push_front(sda_in); void'(hsda.pop_back());
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 start_seen", start_seen, m_s);
            chk("R3 stop_seen", stop_seen, m_p);
            chk("R5 bus_free", bus_free, m_p || (!m_s && !m_p));
            chk("R6 exclusive", start_seen && stop_seen, 1'b0);
            chk("R8 irq_flag", irq_flag, m_flag);
            chk("R10 irq", irq, m_flag && irq_en);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic lines(logic c, logic d);
        scl_in = c; sda_in = d;
    endtask

    task automatic pulse_bd();
        byte_done = 1; tick(1); byte_done = 0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1; tick(1); flag_clr = 0;
    endtask

    task automatic report();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        // R1 reset state
        chk("R1 start_seen", start_seen, 0);
        chk("R1 stop_seen", stop_seen, 0);
        chk("R1 bus_free", bus_free, 1);
        chk("R1 irq_flag", irq_flag, 0);
        chk("R1 irq", irq, 0);
        enable = 1;
        tick(4);

        // R2 START, then R10: irq_en raised while busy
        lines(1, 0); tick(5);
        chk("R2 directed start", start_seen, 1);
        chk("R5 busy", bus_free, 0);
        pulse_clr(); tick(1);
        irq_en = 1; tick(1);
        chk("R10 no irq while busy", irq, 0);

        // R4 SDA toggles with SCL low are ignored
        lines(0, 0); tick(3);
        lines(0, 1); tick(3);
        lines(0, 0); tick(3);
        lines(0, 1); tick(4);
        chk("R4 s kept", start_seen, 1);
        chk("R4 p kept", stop_seen, 0);
        chk("R4 flag untouched", irq_flag, 0);

        // R8 byte done
        pulse_bd(); tick(1);
        chk("R8 byte flag", irq_flag, 1);
        pulse_clr(); tick(1);

        // R3 STOP, R10 irq appears on stop
        lines(0, 0); tick(3);
        lines(1, 0); tick(3);
        lines(1, 1); tick(5);
        chk("R3 directed stop", stop_seen, 1);
        chk("R10 irq on stop", irq, 1);
        chk("R5 free after stop", bus_free, 1);

        // R9 clear colliding with a set event: set wins
        byte_done = 1; flag_clr = 1; tick(1);
        byte_done = 0; flag_clr = 0; tick(1);
        chk("R9 set wins", irq_flag, 1);
        tick(3);
        chk("R9 sticky", irq_flag, 1);
        pulse_clr(); tick(1);
        chk("R9 cleared", irq_flag, 0);

        // R4 SCL and SDA changing together: no condition
        lines(0, 1); tick(3);
        lines(1, 0); tick(5);
        chk("R4 simultaneous", start_seen, 0);
        lines(0, 0); tick(3);
        lines(1, 1); tick(5);

        // R7 disable clears and blocks events
        lines(1, 0); tick(5);
        enable = 0; tick(2);
        chk("R7 s cleared", start_seen, 0);
        pulse_clr(); tick(1);
        lines(1, 1); tick(5);
        pulse_bd(); tick(2);
        chk("R7 stop ignored", stop_seen, 0);
        chk("R7 flag blocked", irq_flag, 0);
        enable = 1; tick(3);

        // random phase under the reference model
        for (int i = 0; i < 4000; i++) begin
            scl_in    = $urandom_range(0, 3) != 0;
            sda_in    = $urandom_range(0, 1);
            byte_done = $urandom_range(0, 15) == 0;
            flag_clr  = $urandom_range(0, 7) == 0;
            irq_en    = $urandom_range(0, 3) != 0;
            enable    = $urandom_range(0, 63) != 0;
            tick($urandom_range(1, 3));
        end
        byte_done = 0; flag_clr = 0;
        tick(5);
        report();
    end

endmodule